// File: doc/BRIEF.md
# Single-Wire Bus Slot Timing Engine

This block is the timing core of a master for a single-wire open-drain bus. Software or a byte-level sequencer hands it one slot command at a time through a request/acknowledge pair. The engine then drives an active-low pull-down enable toward the bus. It holds the line low for the time the slot type calls for, releases it, and reads a synchronized copy of the bus at one defined instant. It reports completion with a one-cycle done pulse.

Four slot types exist. There is a write-0 slot and a write-1 slot. There is a read slot, which returns the bus level. There is a reset sequence, which returns a presence flag: 0 when a device answered, 1 when the line stayed high. All timing is counted in microsecond ticks. A prescaler set by the system clock frequency in MHz produces these ticks. Every duration is multiplied by an integer stretch factor, so the same engine can run slower, more tolerant slots. Byte assembly, device search and CRC are left to the logic above this block.

Top module: `owb_slot_engine`

## Requirements
- R1: A command is accepted only while the engine is idle. `ack` is high in the cycle in which `req` is high and the engine is idle. A `req` raised while a slot is running gives no `ack`, does not alter the running slot and produces no extra `done`.
- R2: A write-1 slot (cmd 2'b01) pulls the line low for 6 us, then releases it for 64 us, and `done` then pulses.
- R3: A write-0 slot (cmd 2'b00) pulls the line low for 60 us, then releases it for 10 us of recovery, and `done` then pulses.
- R4: A read slot (cmd 2'b10) pulls low for 6 us and samples the bus 9 us after release. It completes 55 us after the sample, and `rx_bit` then holds the sampled level.
- R5: A reset sequence (cmd 2'b11) pulls low for 500 us and samples the bus 70 us after release. It stays idle for a further 430 us before `done`. `rx_bit` is 0 if the line was low at the sample, which means a device is present, and 1 if the line was high.
- R6: One microsecond is CLK_MHZ clock cycles. Every duration above is multiplied by STRETCH. A slot from acceptance to `done` therefore lasts exactly (low+release+tail) x STRETCH x CLK_MHZ cycles.
- R7: `done` is high for exactly one cycle per accepted command. `rx_bit` changes only in the cycle where `done` is high. Write slots leave `rx_bit` unchanged.
- R8: After reset the line is released (`bus_drive_n` = 1), and `done`, `ack` and `rx_bit` are 0.
- R9: The bus is read through a two-flop synchronizer at the single sample instant only. A device pulse that ends well before that instant does not affect the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, CLK_MHZ MHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Command request, held until `ack` |
| cmd | input | 2 | Slot type: 00 write-0, 01 write-1, 10 read, 11 reset |
| ack | output | 1 | Command accepted this cycle |
| done | output | 1 | One-cycle completion pulse |
| rx_bit | output | 1 | Read level or presence flag (0 = present) |
| bus_in | input | 1 | Asynchronous bus level |
| bus_drive_n | output | 1 | Pull-down enable, 0 pulls the line low |

## Verification
The bench measures the low time and the total length of every slot type, with the stretch factor set above one. This catches a design that ignores the multiplier or miscounts a phase boundary by a tick, because a single cycle of error shows up. Two read slots use a device pulse placed just before or just covering the sample instant. A design that samples during the whole release window, or at the wrong offset, returns the wrong bit on one of them. A request is raised repeatedly during a running slot. A design that accepts it would show an `ack`, a shortened slot or a second `done`. A write slot follows a read, so a design that overwrites `rx_bit` on writes is caught.

// File: rtl/owb_pkg.sv
package owb_pkg;

  typedef enum logic [1:0] {
    CMD_WR0  = 2'd0,
    CMD_WR1  = 2'd1,
    CMD_READ = 2'd2,
    CMD_RST  = 2'd3
  } owb_cmd_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_WAIT = 2'd2,
    PH_TAIL = 2'd3
  } owb_phase_e;

  // durations in microseconds before stretching
  typedef struct packed {
    logic [9:0] low_us;
    logic [9:0] wait_us;
    logic [9:0] tail_us;
    logic       samples;
  } owb_prof_t;

  function automatic owb_prof_t slot_profile(input owb_cmd_e c);
    owb_prof_t p;
    case (c)
      CMD_WR1:  p = '{low_us: 10'd6,   wait_us: 10'd64, tail_us: 10'd0,   samples: 1'b0};
      CMD_WR0:  p = '{low_us: 10'd60,  wait_us: 10'd10, tail_us: 10'd0,   samples: 1'b0};
      CMD_READ: p = '{low_us: 10'd6,   wait_us: 10'd9,  tail_us: 10'd55,  samples: 1'b1};
      default:  p = '{low_us: 10'd500, wait_us: 10'd70, tail_us: 10'd430, samples: 1'b1};
    endcase
    return p;
  endfunction

endpackage

// File: rtl/owb_us_tick.sv
module owb_us_tick #(
  parameter int CLK_MHZ = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int PRE_W = (CLK_MHZ > 2) ? $clog2(CLK_MHZ) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLK_MHZ - 1);

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] pre_d;

  assign tick = (pre_q == PRE_LAST);

  always_comb begin
    if (restart || tick) pre_d = '0;
    else                 pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end
endmodule

// File: rtl/owb_sync.sv
module owb_sync #(
  parameter int STAGES = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= RST_VAL;
          else        chain_q[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= RST_VAL;
          else        chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/owb_slot_seq.sv
module owb_slot_seq
  import owb_pkg::*;
#(
  parameter int STRETCH = 1
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     req,
  input  owb_cmd_e cmd,
  input  logic     tick,
  input  logic     bus_s,
  output logic     ack,
  output logic     restart,
  output logic     done,
  output logic     rx_bit,
  output logic     drive_low
);
  localparam int CNT_W = 10 + $clog2(STRETCH + 1);
  localparam logic [CNT_W-1:0] STRETCH_C = CNT_W'(STRETCH);

  owb_phase_e       ph_q, ph_d;
  owb_cmd_e         cmd_q, cmd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             smp_q, smp_d;
  logic             rx_q, rx_d;
  logic             done_q, done_d;

  owb_prof_t        prof;
  logic [9:0]       us_sel;
  logic [CNT_W-1:0] ph_len;
  logic             ph_last;
  logic             start;

  assign prof  = slot_profile(cmd_q);
  assign start = (ph_q == PH_IDLE) && req;

  always_comb begin
    case (ph_q)
      PH_LOW:  us_sel = prof.low_us;
      PH_WAIT: us_sel = prof.wait_us;
      PH_TAIL: us_sel = prof.tail_us;
      default: us_sel = 10'd1;
    endcase
  end

  assign ph_len  = CNT_W'(us_sel) * STRETCH_C;
  assign ph_last = tick && (cnt_q == ph_len - 1'b1);

  // next-state logic
  always_comb begin
    ph_d   = ph_q;
    cmd_d  = cmd_q;
    cnt_d  = cnt_q;
    smp_d  = smp_q;
    rx_d   = rx_q;
    done_d = 1'b0;
    case (ph_q)
      PH_IDLE: begin
        if (start) begin
          ph_d  = PH_LOW;
          cmd_d = cmd;
          cnt_d = '0;
        end
      end
      PH_LOW: begin
        if (ph_last) begin
          ph_d  = PH_WAIT;
          cnt_d = '0;
        end else if (tick) begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PH_WAIT: begin
        if (ph_last) begin
          cnt_d = '0;
          if (prof.samples) begin
            smp_d = bus_s;
            ph_d  = PH_TAIL;
          end else begin
            ph_d   = PH_IDLE;
            done_d = 1'b1;
          end
        end else if (tick) begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        if (ph_last) begin
          cnt_d  = '0;
          ph_d   = PH_IDLE;
          rx_d   = smp_q;
          done_d = 1'b1;
        end else if (tick) begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cmd_q  <= CMD_WR1;
      cnt_q  <= '0;
      smp_q  <= 1'b1;
      rx_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      cmd_q  <= cmd_d;
      cnt_q  <= cnt_d;
      smp_q  <= smp_d;
      rx_q   <= rx_d;
      done_q <= done_d;
    end
  end

  assign ack       = start;
  assign restart   = start;
  assign done      = done_q;
  assign rx_bit    = rx_q;
  assign drive_low = (ph_q == PH_LOW);
endmodule

// File: rtl/owb_slot_engine.sv
module owb_slot_engine
  import owb_pkg::*;
#(
  parameter int CLK_MHZ = 4,
  parameter int STRETCH = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req,
  input  logic [1:0] cmd,
  output logic       ack,
  output logic       done,
  output logic       rx_bit,
  input  logic       bus_in,
  output logic       bus_drive_n
);
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;
  logic       tick;
  logic       restart;
  logic       bus_s;
  logic       drive_low;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  owb_us_tick #(.CLK_MHZ(CLK_MHZ)) u_tick (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .restart (restart),
    .tick    (tick)
  );

  owb_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     (bus_in),
    .q     (bus_s)
  );

  owb_slot_seq #(.STRETCH(STRETCH)) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .req       (req),
    .cmd       (owb_cmd_e'(cmd)),
    .tick      (tick),
    .bus_s     (bus_s),
    .ack       (ack),
    .restart   (restart),
    .done      (done),
    .rx_bit    (rx_bit),
    .drive_low (drive_low)
  );

  assign bus_drive_n = ~drive_low;
endmodule

// File: rtl/owb_slot_engine_chk.sv
module owb_slot_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic req,
  input logic ack,
  input logic done,
  input logic rx_bit,
  input logic bus_drive_n,
  input logic tick
);
  // R1: no acceptance while the line is being pulled (slot running)
  assert_no_ack_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_drive_n |-> !ack);

  // R1: an accepted command starts with a low phase
  assert_ack_then_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !bus_drive_n);

  // R1: acceptance only answers a request
  assert_ack_needs_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> req);

  // R7: done lasts one cycle
  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7: result changes only with done
  assert_rx_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(rx_bit));

  // R7: line released at completion
  assert_done_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> bus_drive_n);

  // R6: microsecond tick never on consecutive cycles
  assert_tick_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

bind owb_slot_engine owb_slot_engine_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .req         (req),
  .ack         (ack),
  .done        (done),
  .rx_bit      (rx_bit),
  .bus_drive_n (bus_drive_n),
  .tick        (tick)
);

// File: tb/owb_slot_engine_test.sv
module owb_slot_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int MHZ = 4;
  localparam int STR = 2;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       req;
  logic [1:0] cmd;
  logic       ack, done, rx_bit, bus_drive_n;
  logic       dev_low;
  logic       bus_in;

  int n_chk = 0;
  int n_bad = 0;

  typedef struct {
    logic [1:0] c;
    logic       exp_rx;
    int         exp_len;
    int         exp_low;
    string      tag;
  } exp_t;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  assign bus_in = bus_drive_n & ~dev_low;

  owb_slot_engine #(.CLK_MHZ(MHZ), .STRETCH(STR)) uut (
    .clk(clk), .rst_n(rst_n), .req(req), .cmd(cmd), .ack(ack),
    .done(done), .rx_bit(rx_bit), .bus_in(bus_in), .bus_drive_n(bus_drive_n)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  // profiles from the requirements: low, release, tail in us
  function automatic int low_of(input logic [1:0] c);
    case (c)
      2'b00: return 60;
      2'b01: return 6;
      2'b10: return 6;
      default: return 500;
    endcase
  endfunction
  function automatic int total_of(input logic [1:0] c);
    case (c)
      2'b00: return 60 + 10;
      2'b01: return 6 + 64;
      2'b10: return 6 + 9 + 55;
      default: return 500 + 70 + 430;
    endcase
  endfunction

  // monitor: measures each slot and compares with the queue
  bit running = 0;
  int cyc = 0;
  int lowc = 0;
  always @(negedge clk) begin
    if (running) begin
      if (done) begin
        exp_t e;
        running = 0;
        if (sb.size() == 0) begin
          chk(0, "R7", "done without expectation", 1, 0);
        end else begin
          e = sb.pop_front();
          chk(cyc == e.exp_len, "R6", {e.tag, " slot length"}, cyc, e.exp_len);
          chk(lowc == e.exp_low, e.tag, "low time", lowc, e.exp_low);
          chk(rx_bit == e.exp_rx, e.tag, "rx_bit", rx_bit, e.exp_rx);
        end
      end else begin
        cyc++;
        if (!bus_drive_n) lowc++;
      end
    end else if (done && rst_n) begin
      chk(0, "R7", "spurious done", 1, 0);
    end
    if (ack) begin
      running = 1;
      cyc = 0;
      lowc = 0;
    end
  end

  task automatic run_cmd(input logic [1:0] c, input logic dl, input logic exp_rx,
                         input int wa, input int wb, input string tag);
    exp_t e;
    e.c = c;
    e.exp_rx = exp_rx;
    e.exp_len = total_of(c) * STR * MHZ;
    e.exp_low = low_of(c) * STR * MHZ;
    e.tag = tag;
    sb.push_back(e);
    @(posedge clk); #1;
    dev_low = dl;
    cmd = c;
    req = 1'b1;
    do @(negedge clk); while (!ack);
    @(posedge clk); #1;
    req = 1'b0;
    if (wb > wa) begin
      for (int k = 1; k <= 140; k++) begin
        @(posedge clk); #1;
        dev_low = (k >= wa) && (k < wb);
      end
    end
    do @(negedge clk); while (!done);
    dev_low = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "R1", "watchdog expired", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int acks;
    int dones;
    rst_n = 1'b0;
    req = 1'b0;
    cmd = 2'b00;
    dev_low = 1'b0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R8: reset state
    chk(bus_drive_n == 1'b1, "R8", "bus_drive_n after reset", bus_drive_n, 1);
    chk(done == 1'b0, "R8", "done after reset", done, 0);
    chk(ack == 1'b0, "R8", "ack after reset", ack, 0);
    chk(rx_bit == 1'b0, "R8", "rx_bit after reset", rx_bit, 0);

    run_cmd(2'b01, 1'b0, 1'b0, 0, 0, "R2");   // write-1
    run_cmd(2'b00, 1'b0, 1'b0, 0, 0, "R3");   // write-0
    run_cmd(2'b10, 1'b0, 1'b1, 0, 0, "R4");   // read, line high -> 1
    run_cmd(2'b10, 1'b1, 1'b0, 0, 0, "R4");   // read, device low -> 0
    run_cmd(2'b01, 1'b0, 1'b0, 0, 0, "R7");   // write keeps rx at 0
    run_cmd(2'b11, 1'b1, 1'b0, 0, 0, "R5");   // presence
    run_cmd(2'b11, 1'b0, 1'b1, 0, 0, "R5");   // no device
    // R9: release at cycle 48, bus sampled about cycle 118
    run_cmd(2'b10, 1'b0, 1'b1, 60, 100, "R9"); // pulse ends early
    run_cmd(2'b10, 1'b0, 1'b0, 110, 130, "R9"); // pulse covers sample

    // R1: requests during a running slot are ignored
    begin
      exp_t e;
      e.c = 2'b00;
      e.exp_rx = 1'b0;
      e.exp_len = total_of(2'b00) * STR * MHZ;
      e.exp_low = low_of(2'b00) * STR * MHZ;
      e.tag = "R1";
      sb.push_back(e);
      @(posedge clk); #1;
      cmd = 2'b00;
      req = 1'b1;
      do @(negedge clk); while (!ack);
      @(posedge clk); #1;
      req = 1'b0;
      acks = 0;
      for (int k = 0; k < 40; k++) begin
        @(posedge clk); #1;
        req = 1'b1;
        cmd = 2'b11;
        @(negedge clk);
        if (ack) acks++;
      end
      @(posedge clk); #1;
      req = 1'b0;
      chk(acks == 0, "R1", "ack while busy", acks, 0);
      do @(negedge clk); while (!done);
      dones = 0;
      for (int k = 0; k < 200; k++) begin
        @(negedge clk);
        if (done) dones++;
      end
      chk(dones == 0, "R1", "extra done after ignored req", dones, 0);
    end

    chk(sb.size() == 0, "R7", "pending expectations", sb.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule